// File: doc/BRIEF.md
# Double-Buffered DMA Channel Sequencer

This block sequences one DMA channel through two ping-pong buffer descriptors. Each descriptor holds a start address and a byte count. Software loads a descriptor through a small register write port and enables the channel. The engine then answers peripheral requests one data unit at a time. For each unit it advances a current address and lowers a remaining byte count. When a buffer runs out and the other descriptor is already queued, the channel moves onto it in the next cycle with no idle cycle between them, and it raises a sticky interrupt. Software can then refill the descriptor that was just released.

A 2-bit state code and a buffer-hint bit together tell software which descriptor is in use and which one it may rewrite. The hint bit follows descriptor writes, not transfer progress. If a buffer ends while nothing is queued, the channel parks in a stall state. It resumes as soon as a new descriptor arrives. The bus-master datapath and arbitration between channels are outside this block. It only supplies the address and count and accepts or refuses each request.

Top module: `dbdma_chan`

## Requirements
- R1: After reset the state code is 00 (idle), the buffer hint, the interrupt, the address and the remaining count are all zero, and no request is acknowledged.
- R2: Register selects are 0 = base of descriptor 0, 1 = count of descriptor 0, 2 = base of descriptor 1, 3 = count of descriptor 1, 4 = control (bit 0 enable, bit 1 written as 1 clears the interrupt). Writing a base marks its descriptor loaded, and the count must be written first. An enabled idle channel with a loaded descriptor starts it and shows state 10 (running) with that descriptor's base and count on its outputs.
- R3: A write to the descriptor 0 base sets the buffer hint to 1. A write to the descriptor 1 base clears it to 0.
- R4: While a buffer runs and the other descriptor is loaded, the state is 11 (queued). In normal use, state 10 with hint 1 or state 11 with hint 0 means descriptor 0 is active. State 10 with hint 0 or state 11 with hint 1 means descriptor 1 is active.
- R5: A request is acknowledged in the same cycle only in state 10 or 11. Each acknowledged unit advances the address by XFER_BYTES (4 by default) and lowers the remaining count by XFER_BYTES.
- R6: Loading the other descriptor does not redirect the running buffer. When the running count reaches zero with the other descriptor queued, the next cycle already transfers from the other base with no gap.
- R7: The interrupt is set at each such switch. It stays set until a control write with bit 1 = 1.
- R8: If a buffer ends with no descriptor queued, the state becomes 01 (stall). The address is held past the last unit, the count stays at zero, and requests are refused.
- R9: From stall, loading a descriptor resumes the channel in state 10 on that descriptor, and no interrupt is raised.
- R10: A control write with enable 0 returns the channel to idle, clears the address and count, and discards both loaded descriptors. Re-enabling afterwards stays idle until a descriptor is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | DATA_W | Register write data |
| req_i | input | 1 | Peripheral request for one data unit |
| ack_o | output | 1 | Request accepted this cycle |
| addr_o | output | ADDR_W | Current transfer address |
| remain_o | output | CNT_W | Remaining byte count of the active buffer |
| state_o | output | 2 | Channel state code |
| next_buf_o | output | 1 | Buffer hint |
| nfb_irq_o | output | 1 | Sticky buffer-switch interrupt |

## Verification
Suppose the active-buffer index or a loaded flag is wrong inside the block. The fault shows at the next buffer end: the address jumps to the wrong base, stalls where it should switch, or switches where it should stall. The state code shows a queued flag going wrong one cycle after the register write. A wrong step in the counter is visible on the address of the very next acknowledged unit, so a scoreboard of expected per-unit address and count catches it at once. A missed or spurious interrupt shows at the cycle after the switch.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_STALL = 2'b01,
    ST_ON    = 2'b10,
    ST_NEXT  = 2'b11
  } chan_st_e;

  localparam logic [2:0] SEL_BASE0 = 3'd0;
  localparam logic [2:0] SEL_CNT0  = 3'd1;
  localparam logic [2:0] SEL_BASE1 = 3'd2;
  localparam logic [2:0] SEL_CNT1  = 3'd3;
  localparam logic [2:0] SEL_CTRL  = 3'd4;
endpackage

// File: rtl/dbdma_desc_bank.sv
module dbdma_desc_bank
  import dbdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        consume_i,
  output logic [ADDR_W-1:0] base_o [2],
  output logic [CNT_W-1:0]  cnt_o  [2],
  output logic [1:0]        loaded_o,
  output logic              next_buf_o,
  output logic              en_o,
  output logic              irq_clr_o
);
  logic ctrl_wr, disable_wr;

  assign ctrl_wr    = we_i && (sel_i == SEL_CTRL);
  assign disable_wr = ctrl_wr && !wdata_i[0];
  assign irq_clr_o  = ctrl_wr && wdata_i[1];

  for (genvar b = 0; b < 2; b++) begin : g_desc
    localparam logic [2:0] SelBase = (b == 0) ? SEL_BASE0 : SEL_BASE1;
    localparam logic [2:0] SelCnt  = (b == 0) ? SEL_CNT0  : SEL_CNT1;
    logic base_wr;
    assign base_wr = we_i && (sel_i == SelBase);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[b]   <= '0;
        cnt_o[b]    <= '0;
        loaded_o[b] <= 1'b0;
      end else begin
        if (base_wr) base_o[b] <= wdata_i[ADDR_W-1:0];
        if (we_i && sel_i == SelCnt) cnt_o[b] <= wdata_i[CNT_W-1:0];
        if (disable_wr)        loaded_o[b] <= 1'b0;
        else if (base_wr)      loaded_o[b] <= 1'b1;  // new load wins over consume
        else if (consume_i[b]) loaded_o[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_buf_o <= 1'b0;
      en_o       <= 1'b0;
    end else begin
      if (we_i && sel_i == SEL_BASE0)      next_buf_o <= 1'b1;
      else if (we_i && sel_i == SEL_BASE1) next_buf_o <= 1'b0;
      if (ctrl_wr) en_o <= wdata_i[0];
    end
  end

  assert_hint_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_BASE0) |=> next_buf_o);
  assert_hint_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_BASE1) |=> !next_buf_o);
  assert_discard_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_wr |=> (loaded_o == 2'b00));
endmodule

// File: rtl/dbdma_xfer.sv
module dbdma_xfer #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int XFER_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  remain_o
);
  localparam logic [ADDR_W-1:0] AddrStep = ADDR_W'(XFER_BYTES);
  localparam logic [CNT_W-1:0]  CntStep  = CNT_W'(XFER_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      remain_o <= '0;
    end else if (clr_i) begin
      addr_o   <= '0;
      remain_o <= '0;
    end else if (load_i) begin
      addr_o   <= load_addr_i;
      remain_o <= load_cnt_i;
    end else if (step_i) begin
      addr_o   <= addr_o + AddrStep;
      remain_o <= remain_o - CntStep;
    end
  end

  assert_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !clr_i) |=>
      (addr_o == $past(addr_o) + AddrStep) && (remain_o == $past(remain_o) - CntStep));
  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (remain_o == '0) && (addr_o == '0));
endmodule

// File: rtl/dbdma_fsm.sv
module dbdma_fsm
  import dbdma_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int XFER_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       loaded_i,
  input  logic             irq_clr_i,
  input  logic             req_i,
  input  logic [CNT_W-1:0] remain_i,
  output chan_st_e         state_o,
  output logic             ack_o,
  output logic             start_o,
  output logic             pick_o,
  output logic [1:0]       consume_o,
  output logic             clr_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CntStep = CNT_W'(XFER_BYTES);

  chan_st_e st_q, st_d;
  logic     act_q, last, swap;

  assign ack_o = req_i && (st_q == ST_ON || st_q == ST_NEXT);
  assign last  = ack_o && (remain_i <= CntStep);
  assign clr_o = !en_i;

  always_comb begin
    st_d    = st_q;
    start_o = 1'b0;
    swap    = 1'b0;
    pick_o  = act_q;
    unique case (st_q)
      ST_IDLE: begin
        if (en_i && |loaded_i) begin
          start_o = 1'b1;
          pick_o  = !loaded_i[0];
        end
      end
      ST_STALL: begin
        if (!en_i) st_d = ST_IDLE;
        else if (|loaded_i) begin
          start_o = 1'b1;
          pick_o  = loaded_i[!act_q] ? !act_q : act_q;
        end
      end
      default: begin
        if (!en_i) st_d = ST_IDLE;
        else if (last) begin
          if (loaded_i[!act_q]) begin
            start_o = 1'b1;
            swap    = 1'b1;
            pick_o  = !act_q;
          end else st_d = ST_STALL;
        end else st_d = loaded_i[!act_q] ? ST_NEXT : ST_ON;
      end
    endcase
    if (start_o) st_d = loaded_i[!pick_o] ? ST_NEXT : ST_ON;
  end

  assign consume_o = start_o ? (pick_o ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      act_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_o) act_q <= pick_o;
      if (swap)           irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
    end
  end

  assign state_o = st_q;

  assert_irq_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
  assert_off_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (st_q == ST_IDLE));
  assert_one_consume_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(consume_o));
endmodule

// File: rtl/dbdma_chan.sv
module dbdma_chan
  import dbdma_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int XFER_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              req_i,
  output logic              ack_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  remain_o,
  output logic [1:0]        state_o,
  output logic              next_buf_o,
  output logic              nfb_irq_o
);
  logic [ADDR_W-1:0] base [2];
  logic [CNT_W-1:0]  cnt  [2];
  logic [1:0]        loaded, consume;
  logic              en, irq_clr, start, pick, clr;
  chan_st_e          st;

  dbdma_desc_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bank (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .consume_i(consume),
    .base_o(base), .cnt_o(cnt), .loaded_o(loaded),
    .next_buf_o(next_buf_o), .en_o(en), .irq_clr_o(irq_clr)
  );

  dbdma_fsm #(.CNT_W(CNT_W), .XFER_BYTES(XFER_BYTES)) u_fsm (
    .clk_i, .rst_ni,
    .en_i(en), .loaded_i(loaded), .irq_clr_i(irq_clr),
    .req_i(req_i), .remain_i(remain_o),
    .state_o(st), .ack_o(ack_o), .start_o(start), .pick_o(pick),
    .consume_o(consume), .clr_o(clr), .irq_o(nfb_irq_o)
  );

  dbdma_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .XFER_BYTES(XFER_BYTES)) u_xfer (
    .clk_i, .rst_ni,
    .clr_i(clr), .load_i(start),
    .load_addr_i(base[pick]), .load_cnt_i(cnt[pick]),
    .step_i(ack_o),
    .addr_o(addr_o), .remain_o(remain_o)
  );

  assign state_o = st;

  assert_stall_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_STALL) |-> (remain_o == '0 && !ack_o));
  assert_ack_has_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (remain_o != '0));
endmodule

// File: tb/dbdma_chan_tb_top.sv
module dbdma_chan_tb_top;
  localparam int DW = 32, AW = 32, CW = 16;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [2:0]    reg_sel_i = '0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic          req_i = 1'b0;
  logic          ack_o, next_buf_o, nfb_irq_o;
  logic [AW-1:0] addr_o;
  logic [CW-1:0] remain_o;
  logic [1:0]    state_o;

  typedef struct packed { logic [AW-1:0] a; logic [CW-1:0] r; } beat_t;
  beat_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  dbdma_chan dut_i (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [DW-1:0] d);
    @(posedge clk_i); #1;
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  // expected per-unit address/remaining for a buffer slice
  task automatic push(input logic [AW-1:0] base, input int cnt, input int from, input int n);
    for (int i = from; i < from + n; i++)
      exp_q.push_back({base + AW'(4 * i), CW'(cnt - 4 * i)});
  endtask

  task automatic run(input int n);
    @(posedge clk_i); #1;
    for (int i = 0; i < n; i++) begin
      req_i = 1'b1;
      @(posedge clk_i); #1;
    end
    req_i = 1'b0;
  endtask

  // monitor: compare each accepted unit against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && ack_o) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected ack", addr_o, 0);
      else begin
        beat_t e;
        e = exp_q.pop_front();
        chk(addr_o == e.a, "R5/R6 beat addr", addr_o, e.a);
        chk(remain_o == e.r, "R5/R6 beat remain", remain_o, e.r);
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    cyc(2);
    // R1 reset state
    req_i = 1'b1; #1;
    chk(state_o == 2'b00, "R1 state", state_o, 0);
    chk(!next_buf_o && !nfb_irq_o, "R1 hint/irq", {next_buf_o, nfb_irq_o}, 0);
    chk(!ack_o, "R1 ack", ack_o, 0);
    req_i = 1'b0;
    rst_ni = 1'b1;
    cyc(1);
    chk(addr_o == 0 && remain_o == 0, "R1 addr/remain", remain_o, 0);

    // R2/R3 load descriptor 0 then enable
    wr(3'd1, 16); wr(3'd0, 32'h1000);
    cyc(1);
    chk(next_buf_o == 1'b1, "R3 hint after base0", next_buf_o, 1);
    chk(state_o == 2'b00, "R2 idle until enabled", state_o, 0);
    wr(3'd4, 1); cyc(2);
    chk(state_o == 2'b10, "R2 running", state_o, 2);
    chk(addr_o == 32'h1000 && remain_o == 16, "R2 loaded outputs", addr_o, 32'h1000);

    push(32'h1000, 16, 0, 2); run(2);
    // R4/R6 queue descriptor 1 mid-transfer
    wr(3'd3, 8); wr(3'd2, 32'h2000); cyc(2);
    chk(next_buf_o == 1'b0, "R3 hint after base1", next_buf_o, 0);
    chk(state_o == 2'b11, "R4 queued state", state_o, 3);
    chk(addr_o == 32'h1008, "R6 no redirect", addr_o, 32'h1008);

    push(32'h1000, 16, 2, 2); run(2);
    chk(state_o == 2'b10, "R6 switched state", state_o, 2);
    chk(addr_o == 32'h2000 && remain_o == 8, "R6 gapless load", addr_o, 32'h2000);
    chk(nfb_irq_o, "R7 irq on switch", nfb_irq_o, 1);
    chk(!next_buf_o, "R4 hint names free buffer0 / buf1 active", next_buf_o, 0);

    cyc(3);
    chk(nfb_irq_o, "R7 irq sticky", nfb_irq_o, 1);
    wr(3'd4, 3); cyc(1);
    chk(!nfb_irq_o, "R7 irq cleared", nfb_irq_o, 0);
    chk(state_o == 2'b10, "R7 clear keeps running", state_o, 2);

    // R8 run buffer 1 dry with nothing queued
    push(32'h2000, 8, 0, 2); run(3);
    chk(state_o == 2'b01, "R8 stall state", state_o, 1);
    chk(addr_o == 32'h2008 && remain_o == 0, "R8 held outputs", addr_o, 32'h2008);
    req_i = 1'b1; #1;
    chk(!ack_o, "R8 request refused", ack_o, 0);
    req_i = 1'b0;
    cyc(2);
    chk(addr_o == 32'h2008, "R8 still held", addr_o, 32'h2008);

    // R9 resume on new descriptor
    wr(3'd1, 4); wr(3'd0, 32'h3000); cyc(2);
    chk(state_o == 2'b10, "R9 resumed", state_o, 2);
    chk(addr_o == 32'h3000 && remain_o == 4, "R9 new buffer", addr_o, 32'h3000);
    chk(!nfb_irq_o, "R9 no irq on resume", nfb_irq_o, 0);
    chk(next_buf_o, "R4 hint buf0 active", next_buf_o, 1);

    push(32'h3000, 4, 0, 1); run(1);
    chk(state_o == 2'b01, "R8 stall again", state_o, 1);
    wr(3'd2, 32'h4000); cyc(2);
    chk(state_o == 2'b10 && addr_o == 32'h4000, "R9 resume buf1", addr_o, 32'h4000);

    // R10 queue a descriptor then disable
    wr(3'd0, 32'h5000); cyc(2);
    chk(state_o == 2'b11 && next_buf_o, "R4 queued, buf1 active", state_o, 3);
    wr(3'd4, 0); cyc(2);
    chk(state_o == 2'b00, "R10 idle", state_o, 0);
    chk(addr_o == 0 && remain_o == 0, "R10 cleared", remain_o, 0);
    req_i = 1'b1; #1;
    chk(!ack_o, "R10 no ack", ack_o, 0);
    req_i = 1'b0;
    wr(3'd4, 1); cyc(3);
    chk(state_o == 2'b00, "R10 descriptors discarded", state_o, 0);

    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule